// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer that carries 36-bit words from a producer running on one clock to a consumer running on another. The two clocks run freely. They may have no fixed relation, or they may be the same clock. Each side moves at most one word per rising edge of its own clock, and only while its enable is high. The buffer holds 64 words.

Each side sees flags in its own clock domain. The write side gets full and almost-full, and the read side gets empty and almost-empty. The level at which each "almost" flag asserts is an offset sampled from input ports while reset is held. The binary pointers are converted to Gray code and pass through a two-flop synchronizer before the other domain uses them. A synchronous active-high reset, held across several edges of both clocks, empties the buffer.

Top module: `dcfifo_prog`

## Requirements
- R1: The storage holds 64 words of 36 bits. Words leave the read port in the order in which they were accepted at the write port, with no word lost or repeated.
- R2: A word is accepted only on a rising `wclk` edge with `wr_en` high, and a word is removed only on a rising `rclk` edge with `rd_en` high. Toggling `wr_data` while `wr_en` is low stores nothing.
- R3: A write attempted while `full` is high is dropped, and no internal state changes.
- R4: A read attempted while `empty` is high is dropped, and no internal state changes.
- R5: Once the write side has settled, `full` is high exactly when 64 words are stored. It drops after a read has been seen by the write side.
- R6: Once the read side has settled, `empty` is high exactly when no word is stored.
- R7: Once settled, `almost_full` is high exactly when the number of free locations is less than or equal to the captured almost-full offset.
- R8: Once settled, `almost_empty` is high exactly when the number of stored words is less than or equal to the captured almost-empty offset.
- R9: `af_level` and `ae_level` are captured only on clock edges where `rst` is high. Changing them after reset has no effect on the flags.
- R10: While `rst` is held across edges of both clocks, the buffer empties, `empty` and `almost_empty` go high, and `full` and `almost_full` go low. This holds even if words were stored before reset.
- R11: `rd_data` is a register. It holds the word removed by the `rclk` edge that accepted the read.
- R12: Each pointer changes at most one Gray bit per edge of its own clock, and the buffer works both with unrelated clocks and with `rclk` equal to `wclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| af_level | input | 6 | Almost-full offset in free locations, captured during reset |
| ae_level | input | 6 | Almost-empty offset in stored words, captured during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| full | output | 1 | No free location (write domain) |
| almost_full | output | 1 | Free locations at or below the offset (write domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read word |
| empty | output | 1 | No stored word (read domain) |
| almost_empty | output | 1 | Stored words at or below the offset (read domain) |

## Verification
The hardest case to reach is the exact flag boundaries: one free location against none, and threshold minus one against threshold. The flags react only after the opposite pointer has crossed the synchronizer, so the stimulus fills or drains in directed steps to each boundary, lets both domains settle, and then compares every flag with the count the bench computes. Writes attempted into a full buffer and reads attempted from an empty one are driven on purpose. A data scoreboard then proves that nothing moved. Random phases with both ports active at once run first with unrelated clocks and then with a single shared clock.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  localparam int unsigned GRAY_MAX_W = 32;

  function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] bin_to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] lvl_in,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              full,
  output logic              afull,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0]  wbin, wbin_nx, wgray_nx, rbin_s, used_nx, free_nx, used_now;
  logic [ADDR_W-1:0] lvl_q;
  logic [PTR_W-1:0]  full_cmp;

  assign we       = en & ~full;
  assign waddr    = wbin[ADDR_W-1:0];
  assign wbin_nx  = wbin + {{(PTR_W-1){1'b0}}, we};
  assign wgray_nx = PTR_W'(bin_to_gray(GRAY_MAX_W'(wbin_nx)));
  assign rbin_s   = PTR_W'(gray_to_bin(GRAY_MAX_W'(rgray_s)));
  assign used_nx  = wbin_nx - rbin_s;
  assign free_nx  = DEPTH_P - used_nx;
  assign used_now = wbin - rbin_s;
  assign full_cmp = {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      lvl_q <= lvl_in;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == full_cmp);
      afull <= (free_nx <= {1'b0, lvl_q});
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && full) |=> (wbin == $past(wbin))); // R3
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (rst)
    full |-> afull); // R7
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (rst)
    used_now <= DEPTH_P); // R5
  AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1); // R12

endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] lvl_in,
  input  logic [ADDR_W:0]   wgray_s,
  output logic              empty,
  output logic              aempty,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray
);

  localparam int unsigned PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  rbin, rbin_nx, rgray_nx, wbin_s, cnt_nx;
  logic [ADDR_W-1:0] lvl_q;

  assign re       = en & ~empty;
  assign raddr    = rbin[ADDR_W-1:0];
  assign rbin_nx  = rbin + {{(PTR_W-1){1'b0}}, re};
  assign rgray_nx = PTR_W'(bin_to_gray(GRAY_MAX_W'(rbin_nx)));
  assign wbin_s   = PTR_W'(gray_to_bin(GRAY_MAX_W'(wgray_s)));
  assign cnt_nx   = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      lvl_q  <= lvl_in;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rgray_nx;
      empty  <= (rgray_nx == wgray_s);
      aempty <= (cnt_nx <= {1'b0, lvl_q});
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (en && empty) |=> (rbin == $past(rbin))); // R4
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (rst)
    empty |-> aempty); // R8
  AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1); // R12

endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] af_level,
  input  logic [ADDR_W-1:0] ae_level,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty
);

  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;

  dcfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst(rst), .en(wr_en), .lvl_in(af_level), .rgray_s(rgray_s),
    .full(full), .afull(almost_full), .we(we), .waddr(waddr), .wgray(wgray)
  );

  dcfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst(rst), .en(rd_en), .lvl_in(ae_level), .wgray_s(wgray_s),
    .empty(empty), .aempty(almost_empty), .re(re), .raddr(raddr), .rgray(rgray)
  );

  dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: tb/dcfifo_prog_test.sv
`timescale 1ns/100ps
module dcfifo_prog_test;

  localparam int DW = 36;
  localparam int AW = 6;
  localparam int DEPTH = 64;

  logic wclk = 1'b0, rclk_free = 1'b0, same_clk = 1'b0;
  logic rclk;
  logic rst = 1'b1;
  logic [AW-1:0] af_level = '0, ae_level = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, almost_full, empty, almost_empty;

  int tests = 0, fails = 0;
  int af_cap = 0, ae_cap = 0;
  logic [DW-1:0] model [$];
  int seed_val = 1234;

  always #2 wclk = ~wclk;
  always #3.5 rclk_free = ~rclk_free;
  assign rclk = same_clk ? wclk : rclk_free;

  dcfifo_prog uut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .af_level(af_level), .ae_level(ae_level),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_afull(input int cnt, input int lvl);
    return (DEPTH - cnt) <= lvl;
  endfunction

  function automatic bit exp_aempty(input int cnt, input int lvl);
    return cnt <= lvl;
  endfunction

  task automatic do_reset(input int af, input int ae);
    @(negedge wclk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    af_level = AW'(af); ae_level = AW'(ae);
    af_cap = af; ae_cap = ae;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    rst = 1'b0;
    model.delete();
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic check_flags(input string tag);
    int n = model.size();
    check(full == (n == DEPTH), {tag, " R5 full"}, 64'(full), 64'(n == DEPTH));
    check(empty == (n == 0), {tag, " R6 empty"}, 64'(empty), 64'(n == 0));
    check(almost_full == exp_afull(n, af_cap), {tag, " R7 almost_full"},
          64'(almost_full), 64'(exp_afull(n, af_cap)));
    check(almost_empty == exp_aempty(n, ae_cap), {tag, " R8 almost_empty"},
          64'(almost_empty), 64'(exp_aempty(n, ae_cap)));
  endtask

  task automatic write_cycles(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = (($urandom % 100) < pct);
      wr_data = {$urandom, $urandom} >> 28;
      if (wr_en && !full) model.push_back(wr_data);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic read_cycles(input int n, input int pct);
    bit pend = 1'b0;
    logic [DW-1:0] exp;
    for (int i = 0; i <= n; i++) begin
      @(negedge rclk);
      if (pend) begin
        exp = model.pop_front();
        check(rd_data == exp, "R1 R11 read order/data", 64'(rd_data), 64'(exp));
      end
      rd_en = (i < n) && (($urandom % 100) < pct);
      pend = rd_en && !empty;
    end
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int sz;
    seed_val = $urandom(seed_val);

    // Unrelated clocks
    do_reset(5, 3);
    settle();
    check_flags("R10 after reset");
    // R9: offsets changed after reset must be ignored
    af_level = 6'd40; ae_level = 6'd30;
    // R2: data toggling with wr_en low stores nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge wclk); wr_data = DW'($urandom);
    end
    settle();
    check(empty == 1'b1, "R2 no write without enable", 64'(empty), 64'd1);
    write_cycles(4, 100);
    settle();
    check(almost_empty == 1'b0, "R9 captured ae offset", 64'(almost_empty), 64'd0);
    check(almost_full == 1'b0, "R9 captured af offset", 64'(almost_full), 64'd0);
    check_flags("count4");
    write_cycles(54, 100);
    settle();
    check_flags("count58");
    write_cycles(1, 100);
    settle();
    check_flags("count59");
    // R3: overfill, five attempts dropped
    write_cycles(10, 100);
    settle();
    check(model.size() == DEPTH, "R3 accepted count", 64'(model.size()), 64'(DEPTH));
    check_flags("R3 R5 full");
    read_cycles(60, 100);
    settle();
    check_flags("count4 drain");
    read_cycles(1, 100);
    settle();
    check_flags("count3 drain");
    // R4: over-read
    read_cycles(6, 100);
    settle();
    check(model.size() == 0, "R4 model empty", 64'(model.size()), 64'd0);
    check_flags("R4 R6 empty");
    write_cycles(2, 100);
    settle();
    read_cycles(3, 100);
    settle();
    check_flags("R4 after refill");

    for (int r = 0; r < 3; r++) begin
      fork
        write_cycles(400, 60 + 10 * r);
        read_cycles(300, 70 - 10 * r);
      join
      settle();
      check_flags("R12 random async");
      sz = model.size();
      read_cycles(sz + 2, 100);
      settle();
      check_flags("R12 drained async");
    end

    // R10: reset with words stored
    write_cycles(10, 100);
    settle();
    same_clk = 1'b1;
    do_reset(0, 0);
    settle();
    check_flags("R10 reset while holding data");

    // Coincident clocks
    write_cycles(63, 100);
    settle();
    check_flags("R12 same clk 63");
    write_cycles(3, 100);
    settle();
    check_flags("R12 same clk full");
    read_cycles(63, 100);
    settle();
    check_flags("R12 same clk count1");
    read_cycles(1, 100);
    settle();
    check_flags("R12 same clk empty");
    for (int r = 0; r < 2; r++) begin
      fork
        write_cycles(500, 50 + 30 * r);
        read_cycles(500, 80 - 30 * r);
      join
      settle();
      check_flags("R12 random same clk");
      sz = model.size();
      read_cycles(sz + 1, 100);
      settle();
      check_flags("R12 drained same clk");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule